// File: doc/BRIEF.md
# SCSI DMA Byte-Packing FIFO Controller

This block bridges the byte-wide DMA handshake of a SCSI bus controller and a 32-bit host bus. Bytes from the device are collected in a small byte FIFO and written to memory as 16-bit or 32-bit units. Units fetched from memory are handed to the device one byte at a time. The host side uses a request/grant port, with a bus-error input for faulted cycles. Software drives the block through a 16-bit register window: a control/status register, a 32-bit DMA address and a 32-bit transfer count, each exposed as two halves.

To start a transfer, software loads the address and count and then writes the control register with DMA enabled and both reset bits released. The address advances by the unit size after each host cycle and the count drops by one for each byte moved. When the transfer completes, the block raises a DMA interrupt-pending flag and reports the bytes that did not form a whole unit. The oldest such byte can be read back through a data register. Register accesses made while a transfer is busy are flagged, and a host bus error freezes the transfer until the FIFO is reset.

Top module: `scsi_pack_dma`

## Requirements
- R1: After reset the control/status register reads 0x0400: all control bits are 0 and only FIFO-empty is set. `irq`, `sbc_rst_n` and `host_req` are low.
- R2: The register is selected by byte address bits 4:1, and the window repeats every 32 bytes. Index 0 is control/status, 1 and 2 are the address high and low halves, 3 and 4 are the count high and low halves, 5 is FIFO data, 6 is FIFO count low and 7 is FIFO count high.
- R3: The FIFO byte count and the DMA count are the same register, so a write through index 3 or 4 reads back through index 7 or 6, and the reverse also holds.
- R4: From device to memory (direction bit 3 = 0), the bytes are packed with the earliest byte in bits 7:0. Unit bit 5 = 0 packs 4-byte units and bit 5 = 1 packs 2-byte units, with the upper half zero. Each unit is written at the DMA address, after which the address advances by the unit size. The count decrements by one per byte accepted.
- R5: From memory to device (bit 3 = 1), the block fetches a unit while the count exceeds the FIFO level and the FIFO has room. It delivers the unit's bytes lowest lane first, one per `byte_ack`.
- R6: A transfer completes when the count is zero and either the direction is to-device or fewer than one unit remains in the FIFO. Completion clears busy (bit 14) and sets DMA interrupt pending (bit 8). While idle, bits 7:6 give the FIFO level if it is below one unit, and 0 otherwise. Index 5 returns the oldest FIFO byte in bits 7:0.
- R7: Bit 11 (full) is set when the FIFO holds DEPTH bytes. When the direction is from the device, a full FIFO blocks `byte_ack`. Bit 10 flags an empty FIFO.
- R8: Bit 13 (conflict) sets when any register other than index 0 is read or written while busy. A write to index 0 clears it.
- R9: A host grant with `host_berr` high sets bit 12 and moves no data. The flag is sticky, it blocks `host_req` and `byte_ack`, and only a FIFO reset clears it.
- R10: `irq` is asserted when bit 2 is set and either `sbc_irq` is high or both bit 4 and bit 8 are set. Bit 9 mirrors `sbc_irq`.
- R11: Bit 0 = 0 drives `sbc_rst_n` low and halts data movement. Bit 1 = 0 flushes the FIFO and clears busy, DMA interrupt pending and the bus-error flag. A count write also clears DMA interrupt pending.
- R12: A write to index 0 starts a transfer when the written value has bits 4, 1 and 0 set and the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sbc_irq | input | 1 | Interrupt request from the SCSI controller |
| sbc_rst_n | output | 1 | Reset to the SCSI controller, active low |
| byte_req | input | 1 | Device byte request |
| byte_ack | output | 1 | Byte accepted or delivered this cycle |
| byte_in | input | 8 | Byte from the device |
| byte_out | output | 8 | Byte to the device |
| host_req | output | 1 | Host cycle request |
| host_gnt | input | 1 | Host cycle grant |
| host_berr | input | 1 | Host cycle fault |
| host_we | output | 1 | 1 = the host cycle writes memory |
| host_addr | output | 32 | Host cycle address |
| host_wdata | output | 32 | Packed data to memory |
| host_rdata | input | 32 | Data fetched from memory |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check the per-cycle invariants on every clock. The count drops by exactly one per byte handshake, and the address steps by the unit size per host cycle. The FIFO level never exceeds its depth, and a full FIFO accepts no byte. A bus error stays set and keeps both handshakes quiet. Completion always leaves interrupt pending set, busy always reads zero leftover, and a non-control access while busy sets the conflict flag. Only the bench scenarios can show the byte-lane order of packed and unpacked data, the actual leftover counts and odd-byte readback at the end of real transfers, the register aliasing and window repeat, and the interrupt gating across the enable bits.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int UNIT_W = 3;

  localparam logic [3:0] IDX_CSR    = 4'd0;
  localparam logic [3:0] IDX_ADR_HI = 4'd1;
  localparam logic [3:0] IDX_ADR_LO = 4'd2;
  localparam logic [3:0] IDX_CNT_HI = 4'd3;
  localparam logic [3:0] IDX_CNT_LO = 4'd4;
  localparam logic [3:0] IDX_FDATA  = 4'd5;
  localparam logic [3:0] IDX_FCNT_LO = 4'd6;
  localparam logic [3:0] IDX_FCNT_HI = 4'd7;

  // control bits 5:0 of the control/status register
  typedef struct packed {
    logic word_mode;  // 5: 1 = 16-bit units, 0 = 32-bit units
    logic dma_en;     // 4
    logic to_dev;     // 3: 1 = memory to device
    logic irq_en;     // 2
    logic fifo_run_n; // 1: 0 holds the FIFO in reset
    logic sbc_run_n;  // 0: 0 holds the controller in reset
  } ctl_t;

  function automatic logic [UNIT_W-1:0] unit_bytes(input logic word_mode);
    return word_mode ? UNIT_W'(2) : UNIT_W'(4);
  endfunction

  function automatic logic [31:0] addr_step(input logic [31:0] a, input logic word_mode);
    return a + 32'(unit_bytes(word_mode));
  endfunction
endpackage

// File: rtl/sdp_byte_fifo.sv
module sdp_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [8*LANES-1:0] peek,
  output logic [LW-1:0]      level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + LW'(push_n) - LW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < 32'(push_n)) mem[AW'(wr_ptr + AW'(i))] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek[8*g +: 8] = mem[AW'(rd_ptr + AW'(g))];
  end
endmodule

// File: rtl/sdp_regs.sv
module sdp_regs
  import sdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  idx,
  input  logic [15:0] wdata,
  input  logic        addr_adv,
  input  logic        cnt_dec,
  output ctl_t        ctl,
  output logic [31:0] dma_addr,
  output logic [31:0] xfer_cnt,
  output logic        cnt_wr,
  output logic        addr_wr
);
  logic cnt_hi_wr, cnt_lo_wr, adr_hi_wr, adr_lo_wr;

  assign cnt_hi_wr = wr && (idx == IDX_CNT_HI || idx == IDX_FCNT_HI);
  assign cnt_lo_wr = wr && (idx == IDX_CNT_LO || idx == IDX_FCNT_LO);
  assign adr_hi_wr = wr && idx == IDX_ADR_HI;
  assign adr_lo_wr = wr && idx == IDX_ADR_LO;
  assign cnt_wr    = cnt_hi_wr || cnt_lo_wr;
  assign addr_wr   = adr_hi_wr || adr_lo_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      dma_addr <= '0;
      xfer_cnt <= '0;
    end else begin
      if (wr && idx == IDX_CSR) ctl <= ctl_t'(wdata[5:0]);
      if (adr_hi_wr)      dma_addr[31:16] <= wdata;
      else if (adr_lo_wr) dma_addr[15:0]  <= wdata;
      else if (addr_adv)  dma_addr <= addr_step(dma_addr, ctl.word_mode);
      if (cnt_hi_wr)      xfer_cnt[31:16] <= wdata;
      else if (cnt_lo_wr) xfer_cnt[15:0]  <= wdata;
      else if (cnt_dec)   xfer_cnt <= xfer_cnt - 32'd1;
    end
  end
endmodule

// File: rtl/sdp_xfer.sv
module sdp_xfer
  import sdp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [31:0]       xfer_cnt,
  input  logic [LW-1:0]     level,
  input  logic              start_req,
  input  logic              csr_wr,
  input  logic              other_acc,
  input  logic              cnt_wr,
  input  logic              byte_req,
  input  logic              host_gnt,
  input  logic              host_berr,
  input  logic              sbc_irq,
  output logic              run,
  output logic              dma_ip,
  output logic              berr,
  output logic              conflict,
  output logic              byte_ack,
  output logic              host_req,
  output logic              host_go,
  output logic              done_ev,
  output logic              flush,
  output logic [UNIT_W-1:0] push_n,
  output logic [UNIT_W-1:0] pop_n,
  output logic              irq
);
  logic [UNIT_W-1:0] unit;
  logic [LW-1:0]     unit_l, free;
  logic              halted, active, cnt_nz, berr_ev, start, done_cond;

  assign unit    = unit_bytes(ctl.word_mode);
  assign unit_l  = LW'(unit);
  assign free    = LW'(DEPTH) - level;
  assign flush   = !ctl.fifo_run_n;
  assign halted  = !ctl.sbc_run_n || flush;
  assign active  = run && !berr && !halted;
  assign cnt_nz  = xfer_cnt != 32'd0;

  assign byte_ack = active && byte_req && cnt_nz &&
                    (ctl.to_dev ? level != '0 : level != LW'(DEPTH));
  assign host_req = active && (ctl.to_dev ? (xfer_cnt > 32'(level) && free >= unit_l)
                                          : level >= unit_l);
  assign host_go  = host_req && host_gnt && !host_berr;
  assign berr_ev  = host_req && host_gnt && host_berr;

  assign push_n = ctl.to_dev ? (host_go ? unit : '0) : (byte_ack ? UNIT_W'(1) : '0);
  assign pop_n  = ctl.to_dev ? (byte_ack ? UNIT_W'(1) : '0) : (host_go ? unit : '0);

  assign done_cond = !cnt_nz && (ctl.to_dev || level < unit_l);
  assign done_ev   = active && done_cond;
  assign start     = start_req && cnt_nz;

  assign irq = ctl.irq_en && (sbc_irq || (ctl.dma_en && dma_ip));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      dma_ip   <= 1'b0;
      berr     <= 1'b0;
      conflict <= 1'b0;
    end else begin
      if (start)                 run <= 1'b1;
      else if (flush || done_ev) run <= 1'b0;
      if (flush || cnt_wr)       dma_ip <= 1'b0;
      else if (done_ev)          dma_ip <= 1'b1;
      if (flush)                 berr <= 1'b0;
      else if (berr_ev)          berr <= 1'b1;
      if (csr_wr)                conflict <= 1'b0;
      else if (other_acc && run) conflict <= 1'b1;
    end
  end
endmodule

// File: rtl/scsi_pack_dma.sv
module scsi_pack_dma
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              sbc_irq,
  output logic              sbc_rst_n,
  input  logic              byte_req,
  output logic              byte_ack,
  input  logic [7:0]        byte_in,
  output logic [7:0]        byte_out,
  output logic              host_req,
  input  logic              host_gnt,
  input  logic              host_berr,
  output logic              host_we,
  output logic [31:0]       host_addr,
  output logic [31:0]       host_wdata,
  input  logic [31:0]       host_rdata,
  output logic              irq
);
  ctl_t              ctl;
  logic [3:0]        reg_idx;
  logic [31:0]       dma_addr, xfer_cnt, peek, push_data;
  logic [LW-1:0]     fifo_level;
  logic [UNIT_W-1:0] push_n, pop_n;
  logic              csr_wr, reg_other_acc, start_req, cnt_wr, addr_wr;
  logic              run, dma_ip, berr, conflict, host_go, done_ev, flush;
  logic              fifo_full, fifo_empty;
  logic [1:0]        lob;
  logic [15:0]       csr;
  logic              unused_addr;

  assign reg_idx       = reg_addr[4:1];
  assign unused_addr   = ^{reg_addr[0], reg_addr[ADDR_W-1:5]};
  assign csr_wr        = reg_wr && reg_idx == IDX_CSR;
  assign reg_other_acc = (reg_wr || reg_rd) && reg_idx != IDX_CSR;
  assign start_req     = csr_wr && reg_wdata[4] && reg_wdata[1] && reg_wdata[0];

  sdp_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .addr_adv(host_go), .cnt_dec(byte_ack), .ctl(ctl), .dma_addr(dma_addr),
    .xfer_cnt(xfer_cnt), .cnt_wr(cnt_wr), .addr_wr(addr_wr)
  );

  sdp_xfer #(.DEPTH(DEPTH)) i_xfer (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .xfer_cnt(xfer_cnt), .level(fifo_level),
    .start_req(start_req), .csr_wr(csr_wr), .other_acc(reg_other_acc), .cnt_wr(cnt_wr),
    .byte_req(byte_req), .host_gnt(host_gnt), .host_berr(host_berr), .sbc_irq(sbc_irq),
    .run(run), .dma_ip(dma_ip), .berr(berr), .conflict(conflict), .byte_ack(byte_ack),
    .host_req(host_req), .host_go(host_go), .done_ev(done_ev), .flush(flush),
    .push_n(push_n), .pop_n(pop_n), .irq(irq)
  );

  assign push_data = ctl.to_dev ? host_rdata : {24'd0, byte_in};

  sdp_byte_fifo #(.DEPTH(DEPTH), .LANES(4)) i_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(push_n), .push_data(push_data),
    .pop_n(pop_n), .peek(peek), .level(fifo_level)
  );

  assign fifo_full  = fifo_level == LW'(DEPTH);
  assign fifo_empty = fifo_level == '0;
  assign lob = (!run && fifo_level < LW'(unit_bytes(ctl.word_mode))) ? fifo_level[1:0] : 2'd0;

  assign sbc_rst_n  = ctl.sbc_run_n;
  assign host_we    = !ctl.to_dev;
  assign host_addr  = dma_addr;
  assign host_wdata = ctl.word_mode ? {16'd0, peek[15:0]} : peek;
  assign byte_out   = peek[7:0];

  assign csr = {1'b0, run, conflict, berr, fifo_full, fifo_empty, sbc_irq, dma_ip, lob, ctl};

  always_comb begin
    unique case (reg_idx)
      IDX_CSR:                 reg_rdata = csr;
      IDX_ADR_HI:              reg_rdata = dma_addr[31:16];
      IDX_ADR_LO:              reg_rdata = dma_addr[15:0];
      IDX_CNT_HI, IDX_FCNT_HI: reg_rdata = xfer_cnt[31:16];
      IDX_CNT_LO, IDX_FCNT_LO: reg_rdata = xfer_cnt[15:0];
      IDX_FDATA:               reg_rdata = {8'd0, peek[7:0]};
      default:                 reg_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          berr,
  input logic          dma_ip,
  input logic          conflict,
  input logic          flush,
  input logic          byte_ack,
  input logic          host_req,
  input logic          host_go,
  input logic          cnt_wr,
  input logic          addr_wr,
  input logic          csr_wr,
  input logic          other_acc,
  input logic          done_ev,
  input logic          to_dev,
  input logic          word_mode,
  input logic          full,
  input logic [1:0]    lob,
  input logic [LW-1:0] level,
  input logic [31:0]   xfer_cnt,
  input logic [31:0]   dma_addr
);
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack && !cnt_wr |=> xfer_cnt == $past(xfer_cnt) - 32'd1);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    host_go && !addr_wr |=> dma_addr == $past(dma_addr) + ($past(word_mode) ? 32'd2 : 32'd4));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full && !to_dev |-> !byte_ack);

  a_r9_berr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    berr && !flush |=> berr);

  a_r9_berr_halts: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> !byte_ack && !host_req);

  a_r6_done_sets_ip: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && !cnt_wr && !flush |=> dma_ip && !run);

  a_r6_busy_no_lob: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> lob == 2'd0);

  a_r8_conflict_set: assert property (@(posedge clk) disable iff (!rst_n)
    run && other_acc && !csr_wr |=> conflict);
endmodule

bind scsi_pack_dma sdp_checker #(.DEPTH(DEPTH)) i_sdp_checker (
  .clk(clk), .rst_n(rst_n), .run(run), .berr(berr), .dma_ip(dma_ip), .conflict(conflict),
  .flush(flush), .byte_ack(byte_ack), .host_req(host_req), .host_go(host_go),
  .cnt_wr(cnt_wr), .addr_wr(addr_wr), .csr_wr(csr_wr), .other_acc(reg_other_acc),
  .done_ev(done_ev), .to_dev(ctl.to_dev), .word_mode(ctl.word_mode), .full(fifo_full),
  .lob(lob), .level(fifo_level), .xfer_cnt(xfer_cnt), .dma_addr(dma_addr)
);

// File: tb/test_scsi_pack_dma.sv
module test_scsi_pack_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        sbc_irq = 1'b0, sbc_rst_n;
  logic        byte_req, byte_ack;
  logic [7:0]  byte_in, byte_out;
  logic        host_req, host_gnt, host_berr, host_we, irq;
  logic [31:0] host_addr, host_wdata, host_rdata;

  logic        dev_en = 1'b0, gnt_en = 1'b0, berr_drv = 1'b0;
  logic [7:0]  dev_next = '0;
  logic [7:0]  rx [16];
  int          rx_n = 0;
  logic [31:0] wa [16];
  logic [31:0] wd [16];
  int          wn = 0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign byte_req   = dev_en;
  assign byte_in    = dev_next;
  assign host_gnt   = host_req && gnt_en;
  assign host_berr  = berr_drv;
  assign host_rdata = {pat(host_addr + 3), pat(host_addr + 2), pat(host_addr + 1), pat(host_addr)};

  scsi_pack_dma i_scsi_pack_dma (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sbc_irq(sbc_irq), .sbc_rst_n(sbc_rst_n),
    .byte_req(byte_req), .byte_ack(byte_ack), .byte_in(byte_in), .byte_out(byte_out),
    .host_req(host_req), .host_gnt(host_gnt), .host_berr(host_berr), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  // device and memory models
  always @(posedge clk) begin
    if (byte_ack) begin
      if (host_we) dev_next <= dev_next + 8'd1;
      else if (rx_n < 16) begin rx[rx_n] = byte_out; rx_n++; end
    end
    if (host_req && host_gnt && !host_berr && host_we && wn < 16) begin
      wa[wn] = host_addr; wd[wn] = host_wdata; wn++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 300; i++) begin
      reg_read(8'd0, v);
      if (!v[14]) break;
    end
  endtask

  task automatic prep(input logic [31:0] a, input logic [15:0] n);
    reg_write(8'd0, 16'h0001);            // FIFO held in reset: flush
    reg_write(8'd2, a[31:16]);
    reg_write(8'd4, a[15:0]);
    reg_write(8'd6, 16'h0000);
    reg_write(8'd8, n);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(8'd0, v);
    check("R1", "csr after reset", 32'(v), 32'h0400);
    check("R1", "irq", 32'(irq), 0);
    check("R1", "sbc_rst_n", 32'(sbc_rst_n), 0);
    check("R1", "host_req", 32'(host_req), 0);
  endtask

  task automatic t_window();
    logic [15:0] v;
    reg_write(8'd4, 16'h1234);
    reg_write(8'd2, 16'hABCD);
    reg_read(8'd34, v);
    check("R2", "addr hi via +32 alias", 32'(v), 32'hABCD);
    reg_read(8'd4, v);
    check("R2", "addr lo", 32'(v), 32'h1234);
    reg_write(8'd12, 16'h0009);
    reg_read(8'd8, v);
    check("R3", "fifo count lo -> dma count lo", 32'(v), 32'h0009);
    reg_write(8'd6, 16'h0001);
    reg_read(8'd14, v);
    check("R3", "dma count hi -> fifo count hi", 32'(v), 32'h0001);
    reg_read(8'd40, v);
    check("R2", "count lo via +32 alias", 32'(v), 32'h0009);
  endtask

  task automatic t_read_long();
    logic [15:0] v;
    wn = 0; dev_next = 8'h10; dev_en = 1'b1; gnt_en = 1'b1;
    prep(32'h0000_1000, 16'd10);
    reg_write(8'd0, 16'h0017);
    wait_idle();
    dev_en = 1'b0;
    check("R4", "longword writes", 32'(wn), 2);
    check("R4", "write0 addr", wa[0], 32'h1000);
    check("R4", "write0 data", wd[0], 32'h1312_1110);
    check("R4", "write1 addr", wa[1], 32'h1004);
    check("R4", "write1 data", wd[1], 32'h1716_1514);
    reg_read(8'd0, v);
    check("R6", "csr after odd long read", 32'(v), 32'h0197);
    check("R10", "irq with dma ip", 32'(irq), 1);
    reg_read(8'd10, v);
    check("R6", "leftover byte", 32'(v), 32'h0018);
    reg_read(8'd4, v);
    check("R4", "final addr lo", 32'(v), 32'h1008);
    reg_read(8'd8, v);
    check("R4", "final count", 32'(v), 0);
    reg_write(8'd0, 16'h0007);
    check("R10", "irq with dma_en off", 32'(irq), 0);
    reg_read(8'd0, v);
    check("R10", "dma ip kept", 32'(v), 32'h0187);
  endtask

  task automatic t_read_word();
    logic [15:0] v;
    wn = 0; dev_next = 8'h40; dev_en = 1'b1; gnt_en = 1'b1;
    prep(32'h0000_3000, 16'd5);
    reg_write(8'd0, 16'h0037);
    wait_idle();
    dev_en = 1'b0;
    check("R4", "word writes", 32'(wn), 2);
    check("R4", "word0", wd[0], 32'h0000_4140);
    check("R4", "word1 addr", wa[1], 32'h3002);
    check("R4", "word1", wd[1], 32'h0000_4342);
    reg_read(8'd0, v);
    check("R6", "csr after odd word read", 32'(v), 32'h0177);
    reg_read(8'd10, v);
    check("R6", "odd byte readback", 32'(v), 32'h0044);
    reg_write(8'd8, 16'h0000);
    reg_read(8'd0, v);
    check("R11", "count write clears dma ip", 32'(v), 32'h0077);
  endtask

  task automatic t_write_long();
    logic [15:0] v;
    logic [7:0] e [6] = '{8'h5A, 8'h5B, 8'h58, 8'h59, 8'h5E, 8'h5F};
    rx_n = 0; dev_en = 1'b1; gnt_en = 1'b1;
    prep(32'h0000_2000, 16'd6);
    reg_write(8'd0, 16'h001F);
    wait_idle();
    dev_en = 1'b0;
    check("R5", "bytes delivered", 32'(rx_n), 6);
    for (int i = 0; i < 6; i++) check("R5", "device byte", 32'(rx[i]), 32'(e[i]));
    reg_read(8'd0, v);
    check("R6", "csr after to-device", 32'(v), 32'h019F);
    reg_read(8'd4, v);
    check("R5", "addr after two fetches", 32'(v), 32'h2008);
  endtask

  task automatic t_full();
    logic [15:0] v;
    dev_next = 8'h60; dev_en = 1'b1; gnt_en = 1'b0;
    prep(32'h0000_4000, 16'd12);
    reg_write(8'd0, 16'h0017);
    repeat (20) @(negedge clk);
    reg_read(8'd0, v);
    check("R7", "full and busy", 32'(v), 32'h4817);
    check("R7", "no ack when full", 32'(byte_ack), 0);
    reg_read(8'd8, v);
    check("R7", "count after fill", 32'(v), 4);
    gnt_en = 1'b1;
    wait_idle();
    dev_en = 1'b0;
    reg_read(8'd0, v);
    check("R7", "empty after drain", 32'(v), 32'h2517);
  endtask

  task automatic t_conflict();
    logic [15:0] v;
    dev_en = 1'b0;
    prep(32'h0000_5000, 16'd4);
    reg_write(8'd0, 16'h0017);
    reg_read(8'd0, v);
    check("R12", "busy after start", 32'(v), 32'h4417);
    reg_read(8'd4, v);
    check("R2", "addr read while busy", 32'(v), 32'h5000);
    reg_read(8'd0, v);
    check("R8", "conflict set", 32'(v), 32'h6417);
    reg_write(8'd0, 16'h0017);
    reg_read(8'd0, v);
    check("R8", "conflict cleared by csr write", 32'(v), 32'h4417);
  endtask

  task automatic t_berr();
    logic [15:0] v;
    wn = 0; dev_next = 8'h70; dev_en = 1'b1; gnt_en = 1'b1; berr_drv = 1'b1;
    prep(32'h0000_6000, 16'd4);
    reg_write(8'd0, 16'h0017);
    repeat (20) @(negedge clk);
    berr_drv = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(8'd0, v);
    check("R9", "sticky bus error", 32'(v), 32'h5017);
    check("R9", "host_req blocked", 32'(host_req), 0);
    check("R9", "no host writes", 32'(wn), 0);
    dev_en = 1'b0;
    reg_write(8'd0, 16'h0015);
    reg_read(8'd0, v);
    check("R11", "fifo reset clears error", 32'(v), 32'h0415);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    sbc_irq = 1'b1;
    reg_write(8'd0, 16'h0003);
    reg_read(8'd0, v);
    check("R10", "sbc ip mirrored", 32'(v), 32'h0603);
    check("R10", "irq gated off", 32'(irq), 0);
    check("R11", "sbc_rst_n released", 32'(sbc_rst_n), 1);
    reg_write(8'd0, 16'h0007);
    check("R10", "irq from sbc", 32'(irq), 1);
    reg_write(8'd0, 16'h0006);
    check("R11", "sbc_rst_n held", 32'(sbc_rst_n), 0);
    sbc_irq = 1'b0;
    #1 check("R10", "irq drops", 32'(irq), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset(); t_window(); t_read_long(); t_read_word(); t_write_long();
        t_full(); t_conflict(); t_berr(); t_irq();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung, expected all scenarios done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule